// File: doc/BRIEF.md
# DMA Channel Trigger Collector and Arbiter

This block sits in front of the event queues of a DMA channel controller. It gathers start requests for a set of ordinary DMA channels and a small set of quick channels, keeps one pending bit per channel, and picks one pending channel at a time to hand to the queue logic. The hand-over carries the channel number, whether it is a quick channel, and the queue number programmed for that channel. A valid/ready handshake moves the pick to the queue side.

An ordinary channel can be started in three ways. The first is a rising edge on its own external event line, which is always the line with the same number as the channel and cannot be remapped. The second is a manual trigger through the register write port. The third is a completion report that names it as its chain target. A quick channel starts when its descriptor is written at the one word chosen as its trigger word.

If a channel is triggered again while it is still pending, the block records a per-channel missed-trigger error and raises an error interrupt. Every completion report raises a one-cycle done interrupt. Descriptor fetch and data movement belong to other blocks.

Top module: `dma_trigger_unit`

## Requirements
- R1: A rising edge on `evt_in[i]` makes DMA channel i pending only if enable bit i is 1 at that edge. Edges that arrive while the channel is disabled are dropped and never latched later. A line held high does not trigger again. An enable write (`reg_op`=0, `reg_val[0]` = new value) takes effect from the next cycle.
- R2: A manual write (`reg_op`=1, `reg_idx` = channel) makes that DMA channel pending whatever its enable bit is.
- R3: A completion with `cmp_chain_en`=1 and `cmp_chain_tgt` < NUM_CH makes the target channel pending. With `cmp_chain_en`=0, or with a target of NUM_CH or above, the completion changes no pending bit.
- R4: A quick channel q becomes pending when a descriptor write (`qd_wr`, `qd_ch`=q) hits the word equal to its trigger word. Writes to any other word have no effect. Trigger words reset to 7 and are set with `reg_op`=4, `reg_val[2:0]` = word.
- R5: A trigger to a channel that is already pending and is not granted in the same cycle sets that channel's miss bit. Several triggers to the same channel in one cycle count as one trigger. A miss bit stays set until a clear write (`reg_op`=5, `reg_val[0]`=0 for a DMA channel, 1 for a quick channel). `irq_err` is the OR of all miss bits.
- R6: `req_valid` is 1 exactly when any channel is pending. The offer is the lowest-numbered pending DMA channel. A quick channel is offered, with `req_is_quick`=1, only when no DMA channel is pending, and then the lowest-numbered pending quick channel is offered.
- R7: `req_queue` carries the queue number programmed for the offered channel. DMA channel queues are set with `reg_op`=2 and quick channel queues with `reg_op`=3, both from `reg_val[QW-1:0]`. All queue numbers reset to 0.
- R8: When `req_valid` and `req_ready` are both 1 at a clock edge, the offered channel's pending bit is cleared at that edge. When `req_ready` is 0, nothing pending is lost.
- R9: `irq_done` is 1 in the cycle after each cycle in which `cmp_valid` is 1, and is 0 otherwise.
- R10: After reset nothing is pending, all miss bits are 0, all enables are 0, all queues are 0, all trigger words are 7, and `irq_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_CH | External event lines, line i belongs to channel i |
| reg_wr | input | 1 | Register write strobe |
| reg_op | input | 3 | Write operation code (0 enable, 1 manual, 2 DMA queue, 3 quick queue, 4 trigger word, 5 clear miss) |
| reg_idx | input | 6 | Channel index of the write |
| reg_val | input | 3 | Write value |
| qd_wr | input | 1 | Quick descriptor write strobe |
| qd_ch | input | QIW | Quick channel of the descriptor write |
| qd_word | input | 3 | Descriptor word index written |
| cmp_valid | input | 1 | Completion report strobe |
| cmp_chain_en | input | 1 | Completion requests a chained trigger |
| cmp_chain_tgt | input | 6 | Chain target channel |
| req_ready | input | 1 | Queue side accepts the offer |
| req_valid | output | 1 | An offer is present |
| req_is_quick | output | 1 | Offer is a quick channel |
| req_ch | output | 6 | Offered channel number |
| req_queue | output | QW | Queue number of the offered channel |
| miss_dma | output | NUM_CH | Missed-trigger bits of DMA channels |
| miss_qdma | output | NUM_QCH | Missed-trigger bits of quick channels |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt, OR of all miss bits |

## Verification
The bench builds the block with the small configuration: 16 DMA channels, 8 quick channels and 4 queues. With only 16 channels, the 6-bit chain field and register index can name channels that do not exist, so targets from 16 to 63 test the rule that out-of-range indices are ignored. The short channel list also keeps several channels pending at once, so the lowest-number and DMA-before-quick ordering is exercised often under random ready stalls. With 4 queues, every queue value that can be written is seen at the output.

// File: rtl/dma_trig_pkg.sv
// Package: shared constants and the register write operation codes of the
// DMA trigger unit. Assumes a 6-bit channel index on every external port.
package dma_trig_pkg;

    localparam int IDX_W  = 6;   // channel index width on ports and chain field
    localparam int WORD_W = 3;   // descriptor word index width

    typedef enum logic [2:0] {
        OP_ENABLE     = 3'd0,
        OP_MANUAL     = 3'd1,
        OP_DMA_QUEUE  = 3'd2,
        OP_QDMA_QUEUE = 3'd3,
        OP_TRIG_WORD  = 3'd4,
        OP_CLR_MISS   = 3'd5
    } reg_op_e;

endpackage

// File: rtl/trig_rise_detect.sv
// Module: trig_rise_detect
// Turns N level event lines into one-cycle rising-edge strobes.
// Assumes the lines are already synchronous to clk.
module trig_rise_detect #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // An edge is a line that is high now and was low before.
    always_comb rise = lvl & ~lvl_q;

endmodule

// File: rtl/trig_pend_bank.sv
// Module: trig_pend_bank
// N pending bits with sticky miss bits. A trigger to a bit that is set and
// not cleared in the same cycle records a miss. Trigger wins over clear.
// Assumes trig, clr and miss_clr are single-cycle strobes.
module trig_pend_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] miss_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] miss
);
    // Update pending and miss bits each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            miss <= '0;
        end else begin
            pend <= (pend & ~clr) | trig;
            miss <= (miss & ~miss_clr) | (trig & pend & ~clr);
        end
    end

endmodule

// File: rtl/trig_lowest_pick.sv
// Module: trig_lowest_pick
// Finds the lowest set bit of a request vector. Purely combinational.
// Assumes IW is wide enough to hold N-1.
module trig_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_trigger_unit.sv
// Module: dma_trigger_unit
// Collects event, manual, chain and quick-descriptor triggers, keeps them
// pending and offers the lowest pending channel (DMA before quick) with its
// queue number over a valid/ready handshake.
// Assumes NUM_CH <= 64, NUM_QCH <= 64, NUM_Q <= 8, all inputs synchronous.
module dma_trigger_unit
    import dma_trig_pkg::*;
#(
    parameter int NUM_CH       = 16,
    parameter int NUM_QCH      = 8,
    parameter int NUM_Q        = 4,
    parameter int TRIG_WORD_RST = 7,
    localparam int QIW = (NUM_QCH > 1) ? $clog2(NUM_QCH) : 1,
    localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  evt_in,
    input  logic               reg_wr,
    input  logic [2:0]         reg_op,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [2:0]         reg_val,
    input  logic               qd_wr,
    input  logic [QIW-1:0]     qd_ch,
    input  logic [WORD_W-1:0]  qd_word,
    input  logic               cmp_valid,
    input  logic               cmp_chain_en,
    input  logic [IDX_W-1:0]   cmp_chain_tgt,
    input  logic               req_ready,
    output logic               req_valid,
    output logic               req_is_quick,
    output logic [IDX_W-1:0]   req_ch,
    output logic [QW-1:0]      req_queue,
    output logic [NUM_CH-1:0]  miss_dma,
    output logic [NUM_QCH-1:0] miss_qdma,
    output logic               irq_done,
    output logic               irq_err
);
    localparam int DIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0]  ch_en;
    logic [QW-1:0]      dma_q  [NUM_CH];
    logic [QW-1:0]      qdma_q [NUM_QCH];
    logic [WORD_W-1:0]  qdma_tw[NUM_QCH];

    logic [NUM_CH-1:0]  evt_rise;
    logic [NUM_CH-1:0]  dma_trig, dma_clr, dma_mclr, dma_pend;
    logic [NUM_QCH-1:0] qdma_trig, qdma_clr, qdma_mclr, qdma_pend;
    logic               d_found, q_found, grant;
    logic [DIW-1:0]     d_idx;
    logic [QIW-1:0]     q_idx;

    // Edge detection of the fixed one-to-one event lines.
    trig_rise_detect #(.N(NUM_CH)) u_rise (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (evt_in),
        .rise (evt_rise)
    );

    // Per DMA channel: enable bit, queue number, trigger and clear decode.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dma
        logic sel;
        assign sel = (reg_idx == IDX_W'(i));

        // Hold the enable bit and queue number of channel i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_en[i] <= 1'b0;
                dma_q[i] <= '0;
            end else if (reg_wr && sel) begin
                if (reg_op == OP_ENABLE)    ch_en[i] <= reg_val[0];
                if (reg_op == OP_DMA_QUEUE) dma_q[i] <= reg_val[QW-1:0];
            end
        end

        // Merge event, manual and chain triggers of channel i.
        always_comb begin
            dma_trig[i] = (evt_rise[i] & ch_en[i])
                        | (reg_wr && reg_op == OP_MANUAL && sel)
                        | (cmp_valid && cmp_chain_en && cmp_chain_tgt == IDX_W'(i));
            dma_mclr[i] = reg_wr && reg_op == OP_CLR_MISS && !reg_val[0] && sel;
            dma_clr[i]  = grant && d_found && (d_idx == DIW'(i));
        end
    end

    // Per quick channel: queue number, trigger word, trigger and clear decode.
    for (genvar q = 0; q < NUM_QCH; q++) begin : g_qdma
        logic sel;
        assign sel = (reg_idx == IDX_W'(q));

        // Hold the queue number and trigger word of quick channel q.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                qdma_q[q]  <= '0;
                qdma_tw[q] <= WORD_W'(TRIG_WORD_RST);
            end else if (reg_wr && sel) begin
                if (reg_op == OP_QDMA_QUEUE) qdma_q[q]  <= reg_val[QW-1:0];
                if (reg_op == OP_TRIG_WORD)  qdma_tw[q] <= reg_val;
            end
        end

        // A descriptor write at the trigger word starts quick channel q.
        always_comb begin
            qdma_trig[q] = qd_wr && (qd_ch == QIW'(q)) && (qd_word == qdma_tw[q]);
            qdma_mclr[q] = reg_wr && reg_op == OP_CLR_MISS && reg_val[0] && sel;
            qdma_clr[q]  = grant && !d_found && q_found && (q_idx == QIW'(q));
        end
    end

    // Pending state of the DMA channels.
    trig_pend_bank #(.N(NUM_CH)) u_dbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (dma_trig),
        .clr     (dma_clr),
        .miss_clr(dma_mclr),
        .pend    (dma_pend),
        .miss    (miss_dma)
    );

    // Pending state of the quick channels.
    trig_pend_bank #(.N(NUM_QCH)) u_qbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (qdma_trig),
        .clr     (qdma_clr),
        .miss_clr(qdma_mclr),
        .pend    (qdma_pend),
        .miss    (miss_qdma)
    );

    // Lowest pending DMA channel.
    trig_lowest_pick #(.N(NUM_CH), .IW(DIW)) u_dpick (
        .req  (dma_pend),
        .found(d_found),
        .idx  (d_idx)
    );

    // Lowest pending quick channel.
    trig_lowest_pick #(.N(NUM_QCH), .IW(QIW)) u_qpick (
        .req  (qdma_pend),
        .found(q_found),
        .idx  (q_idx)
    );

    // Build the offer: DMA channels win over quick channels.
    always_comb begin
        req_valid    = d_found | q_found;
        req_is_quick = !d_found && q_found;
        grant        = req_valid && req_ready;
        if (d_found) begin
            req_ch    = IDX_W'(d_idx);
            req_queue = dma_q[d_idx];
        end else if (q_found) begin
            req_ch    = IDX_W'(q_idx);
            req_queue = qdma_q[q_idx];
        end else begin
            req_ch    = '0;
            req_queue = '0;
        end
        irq_err = (|miss_dma) | (|miss_qdma);
    end

    // One-cycle completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_done <= 1'b0;
        else        irq_done <= cmp_valid;
    end

endmodule

// File: rtl/dma_trigger_unit_chk.sv
// Module: dma_trigger_unit_chk
// Property checker bound to dma_trigger_unit. Observes ports and the two
// pending vectors. Assumes synchronous active-low reset.
module dma_trigger_unit_chk
    import dma_trig_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_QCH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [2:0]         reg_op,
    input logic               cmp_valid,
    input logic               req_ready,
    input logic               req_valid,
    input logic               req_is_quick,
    input logic               irq_done,
    input logic [NUM_CH-1:0]  miss_dma,
    input logic [NUM_QCH-1:0] miss_qdma,
    input logic [NUM_CH-1:0]  dma_pend,
    input logic [NUM_QCH-1:0] qdma_pend
);
    // R8: a stalled offer is never lost.
    assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid);

    // R6: a quick offer only when no DMA channel is pending.
    assert_dma_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_is_quick |-> dma_pend == '0);

    // R6: an offer exists exactly when something is pending.
    assert_valid_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid == ((dma_pend != '0) || (qdma_pend != '0)));

    // R9: completion is followed by the done pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> irq_done);

    // R9: no done pulse without a completion.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !irq_done);

    // R5: DMA miss bits stay set without a clear write.
    assert_miss_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_op == OP_CLR_MISS) |=>
        ((miss_dma & $past(miss_dma)) == $past(miss_dma)));

    // R5: quick miss bits stay set without a clear write.
    assert_qmiss_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_op == OP_CLR_MISS) |=>
        ((miss_qdma & $past(miss_qdma)) == $past(miss_qdma)));

endmodule

bind dma_trigger_unit dma_trigger_unit_chk #(
    .NUM_CH (NUM_CH),
    .NUM_QCH(NUM_QCH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_op      (reg_op),
    .cmp_valid   (cmp_valid),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_is_quick(req_is_quick),
    .irq_done    (irq_done),
    .miss_dma    (miss_dma),
    .miss_qdma   (miss_qdma),
    .dma_pend    (dma_pend),
    .qdma_pend   (qdma_pend)
);

// File: tb/sim_dma_trigger_unit.sv
// Bench: directed corner cases and seeded random traffic, each cycle
// compared against a cycle model written from the requirements.
module sim_dma_trigger_unit;
    localparam int NUM_CH  = 16;
    localparam int NUM_QCH = 8;
    localparam int NUM_Q   = 4;
    localparam int QIW     = 3;
    localparam int QW      = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_CH-1:0]  evt_in = '0;
    logic               reg_wr = 1'b0;
    logic [2:0]         reg_op = '0;
    logic [5:0]         reg_idx = '0;
    logic [2:0]         reg_val = '0;
    logic               qd_wr = 1'b0;
    logic [QIW-1:0]     qd_ch = '0;
    logic [2:0]         qd_word = '0;
    logic               cmp_valid = 1'b0;
    logic               cmp_chain_en = 1'b0;
    logic [5:0]         cmp_chain_tgt = '0;
    logic               req_ready = 1'b0;
    logic               req_valid, req_is_quick, irq_done, irq_err;
    logic [5:0]         req_ch;
    logic [QW-1:0]      req_queue;
    logic [NUM_CH-1:0]  miss_dma;
    logic [NUM_QCH-1:0] miss_qdma;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    bit [NUM_CH-1:0]  m_pend, m_miss, m_en, m_prev;
    bit [NUM_QCH-1:0] m_qpend, m_qmiss;
    int               m_dq[NUM_CH];
    int               m_qq[NUM_QCH];
    int               m_tw[NUM_QCH];
    bit               m_done;

    always #10 clk = ~clk;

    dma_trigger_unit #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
        .reg_op(reg_op), .reg_idx(reg_idx), .reg_val(reg_val), .qd_wr(qd_wr),
        .qd_ch(qd_ch), .qd_word(qd_word), .cmp_valid(cmp_valid),
        .cmp_chain_en(cmp_chain_en), .cmp_chain_tgt(cmp_chain_tgt),
        .req_ready(req_ready), .req_valid(req_valid),
        .req_is_quick(req_is_quick), .req_ch(req_ch), .req_queue(req_queue),
        .miss_dma(miss_dma), .miss_qdma(miss_qdma), .irq_done(irq_done),
        .irq_err(irq_err));

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected offer from model state: lowest DMA, else lowest quick.
    task automatic offer(output bit v, output bit qk, output int ch);
        v = 0; qk = 0; ch = 0;
        for (int i = NUM_CH - 1; i >= 0; i--) if (m_pend[i]) begin v = 1; ch = i; end
        if (!v)
            for (int q = NUM_QCH - 1; q >= 0; q--) if (m_qpend[q]) begin v = 1; qk = 1; ch = q; end
    endtask

    task automatic model_reset();
        m_pend = '0; m_miss = '0; m_en = '0; m_prev = '0;
        m_qpend = '0; m_qmiss = '0; m_done = 0;
        for (int i = 0; i < NUM_CH; i++) m_dq[i] = 0;
        for (int q = 0; q < NUM_QCH; q++) begin m_qq[q] = 0; m_tw[q] = 7; end
    endtask

    task automatic compare(string ph);
        bit v, qk; int ch;
        offer(v, qk, ch);
        chk({"R6 req_valid ", ph}, req_valid, v);
        if (v) begin
            chk({"R6 req_is_quick ", ph}, req_is_quick, qk);
            chk({"R6 req_ch ", ph}, req_ch, ch);
            chk({"R7 req_queue ", ph}, req_queue, qk ? m_qq[ch] : m_dq[ch]);
        end
        chk({"R5 miss_dma ", ph}, miss_dma, m_miss);
        chk({"R5 miss_qdma ", ph}, miss_qdma, m_qmiss);
        chk({"R5 irq_err ", ph}, irq_err, (m_miss != 0) || (m_qmiss != 0));
        chk({"R9 irq_done ", ph}, irq_done, m_done);
    endtask

    // One clock: model steps with the inputs present at the edge, then compare.
    task automatic tick(string ph);
        bit v, qk; int ch; bit gnt;
        bit [NUM_CH-1:0] np, nm; bit [NUM_QCH-1:0] nqp, nqm;
        offer(v, qk, ch);
        gnt = v && req_ready;
        @(posedge clk);
        for (int i = 0; i < NUM_CH; i++) begin
            bit t, c, mc;
            t  = (evt_in[i] && !m_prev[i] && m_en[i])
               || (reg_wr && reg_op == 1 && reg_idx == i)
               || (cmp_valid && cmp_chain_en && cmp_chain_tgt == i);
            c  = gnt && !qk && ch == i;
            mc = reg_wr && reg_op == 5 && !reg_val[0] && reg_idx == i;
            np[i] = (m_pend[i] && !c) || t;
            nm[i] = (m_miss[i] && !mc) || (t && m_pend[i] && !c);
        end
        for (int q = 0; q < NUM_QCH; q++) begin
            bit t, c, mc;
            t  = qd_wr && qd_ch == q && qd_word == m_tw[q];
            c  = gnt && qk && ch == q;
            mc = reg_wr && reg_op == 5 && reg_val[0] && reg_idx == q;
            nqp[q] = (m_qpend[q] && !c) || t;
            nqm[q] = (m_qmiss[q] && !mc) || (t && m_qpend[q] && !c);
        end
        if (reg_wr && reg_idx < NUM_CH) begin
            if (reg_op == 0) m_en[reg_idx] = reg_val[0];
            if (reg_op == 2) m_dq[reg_idx] = reg_val[1:0];
        end
        if (reg_wr && reg_idx < NUM_QCH) begin
            if (reg_op == 3) m_qq[reg_idx] = reg_val[1:0];
            if (reg_op == 4) m_tw[reg_idx] = reg_val;
        end
        m_pend = np; m_miss = nm; m_qpend = nqp; m_qmiss = nqm;
        m_prev = evt_in; m_done = cmp_valid;
        #2;
        compare(ph);
        @(negedge clk);
        reg_wr = 0; qd_wr = 0; cmp_valid = 0;
    endtask

    task automatic wr(int op, int idx, int val);
        reg_wr = 1; reg_op = 3'(op); reg_idx = 6'(idx); reg_val = 3'(val);
    endtask

    task automatic qdw(int q, int w);
        qd_wr = 1; qd_ch = QIW'(q); qd_word = 3'(w);
    endtask

    task automatic cmp(bit en, int tgt);
        cmp_valid = 1; cmp_chain_en = en; cmp_chain_tgt = 6'(tgt);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        compare("R10 reset state");

        // R1: edge while disabled is dropped
        evt_in[3] = 1; tick("R1 disabled edge");
        wr(0, 3, 1);   tick("R1 enable write");
        tick("R1 held level no retrigger");
        evt_in[3] = 0; tick("R1 line low");
        evt_in[3] = 1; tick("R1 enabled edge pends");
        // R5: retrigger while pending
        wr(1, 3, 0);   tick("R2 R5 manual on pending");
        // R2: manual ignores enable
        wr(1, 9, 0);   tick("R2 manual disabled channel");
        // R3: chain variants
        cmp(0, 1);     tick("R3 R9 chain disabled");
        cmp(1, 40);    tick("R3 target out of range");
        cmp(1, 1);     tick("R3 chain pends");
        // R7: queue numbers
        wr(2, 1, 3);   tick("R7 dma queue write");
        wr(3, 2, 2);   tick("R7 quick queue write");
        // R4: quick triggers
        qdw(5, 2);     tick("R4 wrong word");
        qdw(5, 7);     tick("R4 reset trigger word");
        wr(4, 2, 2);   tick("R4 trigger word write");
        qdw(2, 2);     tick("R4 new trigger word");
        qdw(2, 2);     tick("R4 R5 quick miss");
        // R8: drain in priority order
        req_ready = 1;
        repeat (6) tick("R8 R6 drain");
        req_ready = 0;
        wr(5, 3, 0);   tick("R5 clear dma miss");
        wr(5, 2, 1);   tick("R5 clear quick miss");
        // R8: grant and retrigger same cycle
        wr(1, 4, 0);   tick("R8 setup");
        req_ready = 1; wr(1, 4, 0); tick("R8 grant with retrigger");
        tick("R8 second grant");
        req_ready = 0;

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NUM_CH; i++)
                if ($urandom_range(7) == 0) evt_in[i] = ~evt_in[i];
            if ($urandom_range(3) == 0)
                wr($urandom_range(5), $urandom_range(19), $urandom_range(7));
            if ($urandom_range(3) == 0)
                qdw($urandom_range(NUM_QCH - 1), $urandom_range(7));
            if ($urandom_range(5) == 0)
                cmp(1'($urandom_range(1)), $urandom_range(63));
            req_ready = 1'($urandom_range(1));
            tick("R1 R2 R3 R4 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule